// File: doc/BRIEF.md
# Four-Channel Time-Slot Display Scanner

This block shares one output bus among four equal-width data sources by giving each source a turn of one clock cycle. A two-bit slot counter steps on every rising clock edge. The data input that belongs to the current slot is routed to the shared output. At the same time, a four-bit active-low select vector marks which channel is being shown.

The typical use is scanning a multi-digit seven-segment display from a single segment bus. The select vector drives the digit enables, and the shared output carries either the segment pattern or a code for the digit. The block has no select input and no handshake with its sources. It rotates continuously from reset, in the order channel 0, 1, 2, 3, then back to 0. Segment decoding and slowing the scan to a visible refresh rate are left to neighbouring logic.

Top module: `tdm_scan_mux`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, slot 0 is selected after that edge: `data_out` equals `d0` and `sel_n` equals 4'b1110.
- R2: While `rst_n` is high, the slot advances by one on every rising edge in the order 0, 1, 2, 3 and wraps from 3 to 0.
- R3: `sel_n` is one-cold, with exactly one bit low at any time. Bit i low marks channel i: 4'b1110 for d0, 4'b1101 for d1, 4'b1011 for d2 and 4'b0111 for d3.
- R4: `data_out` always equals the data input of the channel that `sel_n` marks.
- R5: The reset is synchronous. Lowering `rst_n` between clock edges leaves `data_out` and `sel_n` unchanged until the next rising edge.
- R6: After `rst_n` returns high, the first rising edge moves the scanner from slot 0 to slot 1.
- R7: The path from the selected data input to `data_out` has no register. A change on the shown input appears on `data_out` in the same cycle, without waiting for a clock edge.
- R8: The data width is the parameter `WIDTH`, with a default of 4. The block behaves the same at a width of 7 bits, as used for raw segment data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; the slot steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to slot 0 |
| d3 | input | WIDTH | Data for channel 3 |
| d2 | input | WIDTH | Data for channel 2 |
| d1 | input | WIDTH | Data for channel 1 |
| d0 | input | WIDTH | Data for channel 0 |
| data_out | output | WIDTH | Data of the channel in the current slot |
| sel_n | output | 4 | One-cold channel marker; bit i low means channel i is shown |

## Verification
The only register is the slot counter. The select vector and the slot part of the data output therefore settle one rising edge after the reset level or the previous slot that determines them. A change on the shown data input reaches the output within the same cycle. The bench drives its inputs and samples the outputs at falling edges, so exactly one rising edge lies between a stimulus and the check that covers it. For the same-cycle data path and the synchronous reset, the bench instead samples a few nanoseconds after the stimulus, before any rising edge. A 7-bit instance runs in step with the default-width one, and its rotation is checked at the same sample points.

// File: rtl/tdm_scan_pkg.sv
// Shared constants and types for the time-slot scanner.
// Assumes exactly four channels; the slot width is derived from that count.
package tdm_scan_pkg;
    localparam int NUM_CH = 4;
    localparam int SLOT_W = $clog2(NUM_CH);
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/tdm_slot_counter.sv
// Free-running slot counter: steps once per rising edge and wraps after the
// last channel. Assumes a synchronous active-low reset to slot 0.
module tdm_slot_counter
    import tdm_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t slot
);
    localparam slot_t LAST_SLOT = slot_t'(NUM_CH - 1);

    // Advance the slot, returning to 0 after the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (slot == LAST_SLOT)
            slot <= '0;
        else
            slot <= slot + slot_t'(1);
    end
endmodule

// File: rtl/tdm_select_decoder.sv
// Turns the slot number into a one-cold channel marker (bit i low for slot i).
// Purely combinational; assumes the slot is always below NUM_CH.
module tdm_select_decoder
    import tdm_scan_pkg::*;
(
    input  slot_t             slot,
    output logic [NUM_CH-1:0] sel_n
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        // Pull bit i low only while slot i is active.
        assign sel_n[i] = (slot != slot_t'(i));
    end
endmodule

// File: rtl/tdm_data_mux.sv
// Routes the channel that the slot names onto the shared output.
// Combinational, so a change on the chosen input passes straight through.
module tdm_data_mux
    import tdm_scan_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  slot_t            slot,
    input  logic [WIDTH-1:0] ch [NUM_CH],
    output logic [WIDTH-1:0] data_out
);
    // Select the active channel's data.
    always_comb begin
        data_out = ch[slot];
    end
endmodule

// File: rtl/tdm_scan_mux.sv
// Top of the time-slot scanner. Shares one data bus among four channels,
// one clock cycle each, and marks the shown channel with a one-cold vector.
// Assumes the inputs are valid whenever their slot comes up.
module tdm_scan_mux
    import tdm_scan_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d3,
    input  logic [WIDTH-1:0] d2,
    input  logic [WIDTH-1:0] d1,
    input  logic [WIDTH-1:0] d0,
    output logic [WIDTH-1:0] data_out,
    output logic [3:0]       sel_n
);
    slot_t            slot;
    logic [WIDTH-1:0] ch [NUM_CH];

    // Gather the channel inputs into one indexed array.
    always_comb begin
        ch[0] = d0;
        ch[1] = d1;
        ch[2] = d2;
        ch[3] = d3;
    end

    tdm_slot_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    tdm_select_decoder u_dec (
        .slot  (slot),
        .sel_n (sel_n)
    );

    tdm_data_mux #(.WIDTH(WIDTH)) u_mux (
        .slot     (slot),
        .ch       (ch),
        .data_out (data_out)
    );
endmodule

// File: rtl/tdm_scan_mux_chk.sv
// Property checker for tdm_scan_mux; watches only its ports.
module tdm_scan_mux_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] d3,
    input logic [WIDTH-1:0] d2,
    input logic [WIDTH-1:0] d1,
    input logic [WIDTH-1:0] d0,
    input logic [WIDTH-1:0] data_out,
    input logic [3:0]       sel_n
);
    logic [WIDTH-1:0] marked;

    // Data of the channel that the select vector names.
    always_comb begin
        case (sel_n)
            4'b1110: marked = d0;
            4'b1101: marked = d1;
            4'b1011: marked = d2;
            4'b0111: marked = d3;
            default: marked = ~data_out;
        endcase
    end

    // R1: the first edge with reset released still samples slot 0.
    assert_reset_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sel_n == 4'b1110 && data_out == d0));

    // R2: each running edge rotates the low bit up by one position.
    assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sel_n == {$past(sel_n[2:0]), $past(sel_n[3])});

    // R3: exactly one select bit is low.
    assert_onecold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) == 1);

    // R4: the output carries the marked channel's data.
    assert_data_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_out == marked);
endmodule

bind tdm_scan_mux tdm_scan_mux_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .d3       (d3),
    .d2       (d2),
    .d1       (d1),
    .d0       (d0),
    .data_out (data_out),
    .sel_n    (sel_n)
);

// File: tb/tb_tdm_scan_mux.sv
module tb_tdm_scan_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] d3 = 4'b1100, d2 = 4'b1001, d1 = 4'b0110, d0 = 4'b0011;
    logic [3:0] data_out, sel_n;
    logic [6:0] w3 = 7'h4F, w2 = 7'h5B, w1 = 7'h06, w0 = 7'h3F;
    logic [6:0] w_out;
    logic [3:0] w_sel_n;
    int checks = 0;
    int errors = 0;
    int exp_slot = 0;

    always #4 clk = ~clk;

    tdm_scan_mux dut (.clk(clk), .rst_n(rst_n), .d3(d3), .d2(d2), .d1(d1),
                      .d0(d0), .data_out(data_out), .sel_n(sel_n));

    tdm_scan_mux #(.WIDTH(7)) dut_w7 (.clk(clk), .rst_n(rst_n), .d3(w3),
                      .d2(w2), .d1(w1), .d0(w0), .data_out(w_out), .sel_n(w_sel_n));

    function automatic logic [3:0] exp_d(int s);
        case (s)
            0: return d0;
            1: return d1;
            2: return d2;
            default: return d3;
        endcase
    endfunction

    function automatic logic [6:0] exp_w(int s);
        case (s)
            0: return w0;
            1: return w1;
            2: return w2;
            default: return w3;
        endcase
    endfunction

    task automatic check(string req, logic [6:0] got_d, logic [6:0] want_d,
                         logic [3:0] got_s, logic [3:0] want_s);
        checks++;
        if (got_d !== want_d || got_s !== want_s) begin
            errors++;
            $display("FAIL %s data=%h sel_n=%b expected data=%h sel_n=%b",
                     req, got_d, got_s, want_d, want_s);
        end
    endtask

    task automatic check_slot(string req, int s);
        check(req, {3'b0, data_out}, {3'b0, exp_d(s)}, sel_n, ~(4'b0001 << s));
    endtask

    // R1 and R6: reset holds slot 0, first edge after release gives slot 1.
    task automatic t_reset_start();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_slot("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_slot = 1;
        check_slot("R6", 1);
    endtask

    // R2, R3, R4, R8: two full rotations on both widths.
    task automatic t_rotation();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            exp_slot = (exp_slot + 1) % 4;
            check_slot("R2", exp_slot);
            check("R3", 7'd0, 7'd0, sel_n, ~(4'b0001 << exp_slot));
            check("R8", w_out, exp_w(exp_slot), w_sel_n, ~(4'b0001 << exp_slot));
        end
    endtask

    // R5 and R1: reset lowered mid-rotation acts only at the next edge.
    task automatic t_mid_reset();
        while (exp_slot != 2) begin
            @(negedge clk);
            exp_slot = (exp_slot + 1) % 4;
        end
        check_slot("R4", 2);
        rst_n = 1'b0;
        #1;
        check_slot("R5", 2);
        @(negedge clk);
        check_slot("R1", 0);
        @(negedge clk);
        check_slot("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_slot = 1;
        check_slot("R6", 1);
    endtask

    // R7: the shown input passes through in the same cycle.
    task automatic t_passthrough();
        logic [3:0] saved;
        saved = d1;
        #1;
        d1 = 4'b1010;
        #1;
        check_slot("R7", 1);
        d3 = 4'b0101;
        #1;
        check_slot("R7", 1);
        d1 = saved;
        d3 = 4'b1100;
    endtask

    initial begin
        t_reset_start();
        t_passthrough();
        t_rotation();
        t_mid_reset();
        t_rotation();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule